// File: doc/BRIEF.md
# Sample Write Master for Capture Memory

This block moves captured converter samples into external memory without processor involvement. Capture logic presents a pair of 16-bit results, one per channel, on a valid strobe. The block buffers them and drains them as single-beat 16-bit bus writes. Each write carries a 32-bit byte address and a full byte enable. The bus target may stall any write by holding a wait-request line.

Software sets up a job with a start address, a number of samples and an address mode, then pulses start. In the incrementing mode, consecutive samples land at consecutive 16-bit locations. In the fixed mode, every sample is written to the start address, which suits a memory-mapped port or a scope-style probe. A small buffer absorbs bus stalls. Samples that find it full are discarded, and a sticky flag records the loss. A done flag rises once the last requested write has been accepted.

Top module: `sample_wr_master`

## Requirements
- R1: After reset, `wr_en`, `busy`, `done` and `overflow` are all 0.
- R2: A start pulse while idle latches `base_addr`, `sample_count` and `fixed_mode`. The first write of the job goes to `base_addr`.
- R3: With `fixed_mode` = 0, each accepted write is followed by a write whose address is 2 higher, modulo 2^32.
- R4: With `fixed_mode` = 1, every write of the job uses `base_addr`.
- R5: While `wr_en` and `wr_wait` are both 1, the next cycle keeps `wr_en` at 1 and keeps `wr_addr` and `wr_data` unchanged.
- R6: `wr_be` is 2'b11 on every write.
- R7: Each sample pair is stored as two samples in order: `smp_a` first, then `smp_b`. When the count is odd, the final `smp_b` is not written.
- R8: Exactly `sample_count` writes are accepted. After the last one, `busy` falls and `done` rises. `done` stays set until the next start.
- R9: A start with `sample_count` = 0 sets `done` on the next clock edge, leaves `busy` at 0 and issues no write.
- R10: The buffer holds 8 samples. A sample arriving when no entry is free is dropped and does not count toward the job. `overflow` is then set, stays set for the rest of the job, and is cleared by the next start.
- R11: Sample strobes while `busy` is 0 are ignored, and no write is issued while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job (ignored while busy) |
| base_addr | input | 32 | Byte address of the first write |
| sample_count | input | 16 | Number of samples to store |
| fixed_mode | input | 1 | 1: all writes to base_addr; 0: incrementing |
| smp_valid | input | 1 | A new channel pair is present |
| smp_a | input | 16 | Channel A sample |
| smp_b | input | 16 | Channel B sample |
| wr_wait | input | 1 | Bus stall for the current write |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 32 | Write byte address |
| wr_be | output | 2 | Byte enables |
| wr_data | output | 16 | Write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | Sticky job completion |
| overflow | output | 1 | Sticky sample loss in the current job |

## Verification
The bench builds the block with its default parameters: 16-bit data, 32-bit addresses, a 16-bit count and an 8-entry buffer. The shallow buffer lets a stalled bus fill it after only five sample pairs, so the drop path and the sticky flag are reached within a few cycles. The 32-bit address also allows a job based four bytes below the top of the address space, which exercises wrap-around. Stall patterns are paced so that ordinary jobs never overflow, which keeps their address and data sequences fully predictable.

// File: rtl/swm_pkg.sv
// Shared definitions for the sample write master.
// Assumes: data width is a whole number of bytes.
package swm_pkg;

    typedef enum logic [0:0] {
        JOB_IDLE = 1'b0,
        JOB_RUN  = 1'b1
    } job_state_t;

endpackage

// File: rtl/swm_fifo.sv
// Sample buffer that can take two words per cycle and return one.
// Word A is stored ahead of word B. A word that finds no free entry is
// dropped, and a drop pulse is raised. Free space is judged before the
// same-cycle pop, so the check errs on the safe side.
// Assumes: DEPTH is a power of two; pop is only raised when not empty.
module swm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push_a,
    input  logic [W-1:0] data_a,
    input  logic         push_b,
    input  logic [W-1:0] data_b,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic [1:0]   n_taken,
    output logic         drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [CW-1:0] free;
    logic          take_a, take_b;

    // Decide which of the offered words fit.
    always_comb begin
        free    = CW'(DEPTH) - cnt;
        take_a  = push_a && (free != '0);
        take_b  = push_b && (free > CW'(take_a));
        n_taken = {1'b0, take_a} + {1'b0, take_b};
        drop    = (push_a && !take_a) || (push_b && !take_b);
        head    = mem[rp];
        empty   = (cnt == '0);
    end

    // Store the accepted words; B follows A when both are taken.
    always_ff @(posedge clk) begin
        if (take_a) mem[wp] <= data_a;
        if (take_b) mem[wp + PW'(take_a)] <= data_b;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            wp  <= wp + PW'(n_taken);
            rp  <= rp + PW'(pop);
            cnt <= cnt + CW'(n_taken) - CW'(pop);
        end
    end
endmodule

// File: rtl/swm_bus.sv
// Bus output stage: holds one write on the bus until it is accepted,
// then loads the next word from the buffer. It produces the address
// sequence, either fixed or stepping by the data width in bytes.
// Assumes: load_base is only raised while no write is pending.
module swm_bus #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [ADDR_W-1:0] base,
    input  logic              fixed,
    input  logic              active,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              wr_wait,
    output logic              fifo_pop,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fire
);
    localparam int STEP = DATA_W / 8;

    logic [ADDR_W-1:0] next_addr;
    logic              slot_free;

    // The slot frees up when empty or when the current write is taken.
    always_comb begin
        slot_free = !wr_en || !wr_wait;
        fifo_pop  = slot_free && active && !fifo_empty;
        fire      = wr_en && !wr_wait;
    end

    // Load, hold or retire the bus write and advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            next_addr <= '0;
        end else if (load_base) begin
            wr_en     <= 1'b0;
            next_addr <= base;
        end else if (fifo_pop) begin
            wr_en     <= 1'b1;
            wr_addr   <= next_addr;
            wr_data   <= fifo_head;
            next_addr <= fixed ? next_addr : next_addr + ADDR_W'(STEP);
        end else if (slot_free) begin
            wr_en <= 1'b0;
        end
    end
endmodule

// File: rtl/swm_ctrl.sv
// Job controller: latches the job settings, limits how many samples
// enter the buffer, counts completed writes, and keeps the done and
// overflow flags.
// Assumes: start is ignored while a job runs.
module swm_ctrl
    import swm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] sample_count,
    input  logic             fixed_mode,
    input  logic             smp_valid,
    input  logic [1:0]       n_taken,
    input  logic             drop,
    input  logic             fire,
    output logic             begin_job,
    output logic             push_a,
    output logic             push_b,
    output logic             fixed_lat,
    output logic             busy,
    output logic             done,
    output logic             overflow
);
    job_state_t       state;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] accepted;
    logic [CNT_W-1:0] written;

    // Gate the sample pair against the remaining job budget.
    always_comb begin
        busy      = (state == JOB_RUN);
        begin_job = start && !busy;
        push_a    = busy && smp_valid && (accepted < count_q);
        push_b    = busy && smp_valid &&
                    ({1'b0, accepted} + 1'b1 < {1'b0, count_q});
    end

    // Job sequencing, sample and write counting, flag upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= JOB_IDLE;
            count_q   <= '0;
            accepted  <= '0;
            written   <= '0;
            fixed_lat <= 1'b0;
            done      <= 1'b0;
            overflow  <= 1'b0;
        end else if (begin_job) begin
            count_q   <= sample_count;
            accepted  <= '0;
            written   <= '0;
            fixed_lat <= fixed_mode;
            overflow  <= 1'b0;
            done      <= (sample_count == '0);
            state     <= (sample_count == '0) ? JOB_IDLE : JOB_RUN;
        end else if (busy) begin
            accepted <= accepted + CNT_W'(n_taken);
            if (drop) overflow <= 1'b1;
            if (fire) begin
                written <= written + 1'b1;
                if (written + 1'b1 == count_q) begin
                    state <= JOB_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sample_wr_master.sv
// Top of the sample write master: controller, two-input buffer and
// bus output stage. Channel pairs are stored A then B, and each word
// becomes one full-width bus write.
// Assumes: the bus target accepts a write in any cycle where wr_wait is low.
module sample_wr_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  sample_count,
    input  logic              fixed_mode,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_a,
    input  logic [DATA_W-1:0] smp_b,
    input  logic              wr_wait,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W/8-1:0] wr_be,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              overflow
);
    localparam int BE_W = DATA_W / 8;

    logic              begin_job, push_a, push_b, fixed_lat;
    logic [1:0]        n_taken;
    logic              drop, fire, fifo_pop, fifo_empty;
    logic [DATA_W-1:0] fifo_head;

    // Every write covers the full data width.
    always_comb wr_be = {BE_W{1'b1}};

    swm_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sample_count(sample_count), .fixed_mode(fixed_mode),
        .smp_valid(smp_valid), .n_taken(n_taken), .drop(drop),
        .fire(fire), .begin_job(begin_job), .push_a(push_a),
        .push_b(push_b), .fixed_lat(fixed_lat), .busy(busy),
        .done(done), .overflow(overflow)
    );

    swm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clear(begin_job),
        .push_a(push_a), .data_a(smp_a), .push_b(push_b), .data_b(smp_b),
        .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty),
        .n_taken(n_taken), .drop(drop)
    );

    swm_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
        .clk(clk), .rst_n(rst_n), .load_base(begin_job), .base(base_addr),
        .fixed(fixed_lat), .active(busy), .fifo_empty(fifo_empty),
        .fifo_head(fifo_head), .wr_wait(wr_wait), .fifo_pop(fifo_pop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fire(fire)
    );
endmodule

// File: rtl/swm_checker.sv
// Protocol and sequencing properties for the sample write master,
// attached to every instance of the top module.
module swm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wr_en,
    input logic              wr_wait,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W/8-1:0] wr_be,
    input logic              busy,
    input logic              done,
    input logic              overflow,
    input logic              fixed_lat
);
    localparam int STEP = DATA_W / 8;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_wait |=> wr_en && $stable(wr_addr) && $stable(wr_data));

    assert_full_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_be == {STEP{1'b1}});

    assert_fixed_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_wait && fixed_lat |=> !wr_en || wr_addr == $past(wr_addr));

    assert_step_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_wait && !fixed_lat |=>
            !wr_en || wr_addr == $past(wr_addr) + ADDR_W'(STEP));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_no_overflow_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !start |=> overflow);
endmodule

bind sample_wr_master swm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
    .wr_wait(wr_wait), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .busy(busy), .done(done), .overflow(overflow),
    .fixed_lat(fixed_lat)
);

// File: tb/sample_wr_master_tb_top.sv
module sample_wr_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] sample_count = '0;
    logic        fixed_mode = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_a = '0, smp_b = '0;
    logic        wr_wait;
    logic        wr_en, busy, done, overflow;
    logic [31:0] wr_addr;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;

    int errs = 0, checks = 0;
    int stall_mod = 0;
    int cyc = 0;
    int log_n = 0;
    int be_bad = 0;
    logic [31:0] log_addr [256];
    logic [15:0] log_data [256];

    always #5 clk = ~clk;

    sample_wr_master dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .sample_count(sample_count), .fixed_mode(fixed_mode),
        .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .wr_wait(wr_wait), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .busy(busy), .done(done), .overflow(overflow)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Drive the stall line, then log the write the next edge will accept.
    initial wr_wait = 1'b0;
    always @(negedge clk) begin
        logic w;
        w = (stall_mod != 0) && (cyc % stall_mod == 0);
        wr_wait = w;
        if (wr_en && !w) begin
            if (log_n < 256) begin
                log_addr[log_n] = wr_addr;
                log_data[log_n] = wr_data;
            end
            log_n = log_n + 1;
            if (wr_be != 2'b11) be_bad = be_bad + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic kick(input logic [31:0] b, input logic [15:0] n, input logic f);
        @(negedge clk);
        base_addr = b; sample_count = n; fixed_mode = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int npairs, input int first, input int gap);
        for (int p = 0; p < npairs; p++) begin
            smp_valid = 1'b1;
            smp_a = 16'hA000 | 16'(first + p);
            smp_b = 16'hB000 | 16'(first + p);
            @(negedge clk);
            smp_valid = 1'b0;
            for (int g = 1; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic wait_done();
        for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    endtask

    localparam int NV = 4;
    localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0040_0000,
                                           32'h0000_0200, 32'hFFFF_FFFC};
    localparam int V_CNT  [NV] = '{6, 7, 5, 4};
    localparam bit V_FIX  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam int V_STL  [NV] = '{0, 4, 3, 0};
    localparam int V_GAP  [NV] = '{3, 3, 4, 1};

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
        finish_run();
    end

    initial begin
        logic [31:0] held_a;
        logic [15:0] held_d;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!wr_en && !busy && !done && !overflow, "R1",
              {wr_en, busy, done, overflow}, 0);

        // R11 strobes while idle are ignored
        s0 = log_n;
        feed(3, 0, 1);
        repeat (4) @(negedge clk);
        check(log_n == s0 && !wr_en && !busy, "R11", log_n - s0, 0);

        // Table of jobs: R2 R3 R4 R7 R8
        for (int v = 0; v < NV; v++) begin
            stall_mod = V_STL[v];
            kick(V_BASE[v], 16'(V_CNT[v]), V_FIX[v]);
            s0 = log_n;
            feed((V_CNT[v] + 1) / 2, 0, V_GAP[v]);
            wait_done();
            stall_mod = 0;
            repeat (3) @(negedge clk);
            check(log_n - s0 == V_CNT[v], "R8 count", log_n - s0, V_CNT[v]);
            check(done && !busy, "R8 done", {done, busy}, 2'b10);
            check(!overflow, "R10 no loss", overflow, 0);
            for (int k = 0; k < V_CNT[v]; k++) begin
                logic [31:0] ea;
                logic [15:0] ed;
                ea = V_FIX[v] ? V_BASE[v] : V_BASE[v] + 32'(2 * k);
                ed = ((k % 2) == 0 ? 16'hA000 : 16'hB000) | 16'(k / 2);
                check(log_addr[s0 + k] == ea,
                      V_FIX[v] ? "R4 addr" : (k == 0 ? "R2 addr" : "R3 addr"),
                      log_addr[s0 + k], ea);
                check(log_data[s0 + k] == ed, "R7 data", 32'(log_data[s0 + k]),
                      32'(ed));
            end
        end

        // R9 zero count
        s0 = log_n;
        kick(32'h0000_3000, 16'd0, 1'b0);
        check(done && !busy, "R9 done", {done, busy}, 2'b10);
        feed(2, 0, 1);
        repeat (4) @(negedge clk);
        check(log_n == s0, "R9 no write", log_n - s0, 0);

        // R10 overflow under a full stall, R5 hold
        stall_mod = 1;
        kick(32'h0000_4000, 16'd20, 1'b0);
        check(!overflow && !done, "R10 clear on start", {overflow, done}, 0);
        s0 = log_n;
        feed(5, 0, 1);
        check(overflow == 1'b1, "R10 set", overflow, 1);
        held_a = wr_addr; held_d = wr_data;
        repeat (3) @(negedge clk);
        check(wr_en && wr_addr == held_a && wr_data == held_d, "R5 hold",
              wr_addr, held_a);
        check(wr_addr == 32'h0000_4000, "R2 first addr", wr_addr, 32'h4000);
        stall_mod = 0;
        feed(15, 5, 2);
        wait_done();
        repeat (2) @(negedge clk);
        check(log_n - s0 == 20 && done, "R10 job completes", log_n - s0, 20);
        check(overflow == 1'b1, "R10 sticky", overflow, 1);
        kick(32'h0, 16'd0, 1'b0);
        check(overflow == 1'b0, "R10 cleared", overflow, 0);

        // R6 byte enables on every logged write
        check(be_bad == 0, "R6 byte enable", be_bad, 0);
        finish_run();
    end
endmodule